// File: doc/BRIEF.md
# Jitter-Attenuating Frequency-Tracking Loop

This block is the slow numeric loop of a two-loop clock recovery arrangement. Everything in it runs on one fast, fixed-rate system clock taken from a free-running crystal. An external reference square wave, such as an audio word clock, is brought into that domain through a synchronizer. Each of its rising edges is then timestamped against a local phase accumulator. The accumulator is a numerically controlled oscillator stepped by the block's own frequency word. When it wraps, it emits the local frame-sync pulse. The accumulator value seen at a reference edge is the phase error between the frame-sync and the reference.

A proportional-plus-integral filter acts on each error sample, with both gains set by arithmetic right shifts. The integral path is clamped between programmable minimum and maximum words. The proportional-plus-integral target is clamped the same way. The published word then moves toward that target by no more than a programmable step per update. Because of this step limit, a rate change or a sudden reference phase jump becomes a glide rather than a jump, and the lock flag can ride through it. A lock monitor counts runs of small and large errors. A timeout detects a missing reference, clears lock and freezes the loop until the reference comes back.

The word leaves as a stream: `fw_word` qualified by a one-cycle `fw_valid`. There is no ready signal and no back-pressure. The consumer must accept every strobe, and the word is held steady between strobes. The configuration pins are plain static controls.

Top module: `jitter_track_loop`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block loads `fw_word` from `cfg_fw_init` and holds `fw_valid`, `locked` and `frame_pulse` at 0. Reset is synchronous.
- R2: `ref_in` passes through a two-flop synchronizer. A rising edge is recognised when the second stage is 1 and the third is 0. The filter update strobe `fw_valid` is high in the cycle after the fourth clock edge at which `ref_in` has been high.
- R3: The 32-bit phase accumulator adds `fw_word` every cycle. The error captured at a recognised edge is the negation of accumulator bits [31:8] read as a 24-bit signed number. The value -2^23 maps to +2^23-1.
- R4: At each update, the integrator adds the error arithmetically shifted right by `cfg_ki_shift`. The result is clamped to [`cfg_fw_min`, `cfg_fw_max`].
- R5: The target is the new integrator value plus the error arithmetically shifted right by `cfg_kp_shift`, clamped to [`cfg_fw_min`, `cfg_fw_max`].
- R6: At each update, `fw_word` moves to the target if it is within `cfg_slew_step`. Otherwise it moves exactly `cfg_slew_step` toward the target.
- R7: `fw_valid` is high for exactly one cycle per update. `fw_word` changes only in cycles where `fw_valid` is high.
- R8: `frame_pulse` is high for one cycle after each accumulator addition that carries out of bit 31.
- R9: A sample with absolute error below `cfg_lock_thr` counts as good. `locked` rises on the 16th consecutive good sample.
- R10: A sample with absolute error above `cfg_unlock_thr` counts as bad and clears the good run. `locked` falls on the 4th consecutive bad sample.
- R11: When `cfg_timeout` cycles pass with no recognised edge, the block enters a stale state. In that state `locked` drops, the good and bad runs clear, and `fw_word` is held. The first edge after the stale state only re-arms the loop and produces no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed-rate system clock, the only time base |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Asynchronous reference square wave |
| cfg_fw_init | input | 32 | Frequency word loaded at reset |
| cfg_fw_min | input | 32 | Lower clamp for integrator and target |
| cfg_fw_max | input | 32 | Upper clamp for integrator and target |
| cfg_slew_step | input | 32 | Largest change of `fw_word` per update |
| cfg_kp_shift | input | 5 | Right shift setting the proportional gain |
| cfg_ki_shift | input | 5 | Right shift setting the integral gain |
| cfg_lock_thr | input | 23 | Good-sample limit on absolute error |
| cfg_unlock_thr | input | 23 | Bad-sample limit on absolute error |
| cfg_timeout | input | 20 | Cycles without an edge before stale |
| fw_word | output | 32 | Frequency control word stream data |
| fw_valid | output | 1 | One-cycle strobe marking a new word |
| locked | output | 1 | Lock indication |
| frame_pulse | output | 1 | Local frame-sync pulse aligned by the loop |

## Verification
The assertions take several things for granted. `cfg_fw_init` lies inside [`cfg_fw_min`, `cfg_fw_max`], and `cfg_slew_step` stays constant. The reference stays high and low for at least two cycles each, so strobes can never fall in adjacent cycles. `cfg_timeout` is far longer than the synchronizer latency. The stimulus meets all of these. It changes the clamps and the lock thresholds only while the reference is running, and it never touches the step or the initial word after reset. It toggles `ref_in` only on falling clock edges, with periods of tens of cycles. It drives steady periods, alternating jittered periods, a rate change, a tightened clamp and a long gap that exceeds the timeout.

// File: rtl/jtl_pkg.sv
package jtl_pkg;
  typedef enum logic [0:0] {
    LK_SEARCH = 1'b0,
    LK_HELD   = 1'b1
  } lock_state_e;
endpackage

// File: rtl/jtl_edge_sync.sv
module jtl_edge_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int TO_W        = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_in,
  input  logic [TO_W-1:0] cfg_timeout,
  output logic            edge_seen,
  output logic            stale
);
  localparam int SH_W = SYNC_STAGES + 1;
  localparam logic [TO_W-1:0] TO_MAX = {TO_W{1'b1}};

  logic [SH_W-1:0] shreg;
  logic [TO_W-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[SH_W-2:0], ref_in};
  end

  assign edge_seen = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n)                 idle_cnt <= '0;
    else if (edge_seen)         idle_cnt <= '0;
    else if (idle_cnt != TO_MAX) idle_cnt <= idle_cnt + 1'b1;
  end

  assign stale = (idle_cnt >= cfg_timeout);

  assert_edge_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> !edge_seen);
endmodule

// File: rtl/jtl_phase_det.sv
module jtl_phase_det #(
  parameter int ACC_W = 32,
  parameter int ERR_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ACC_W-1:0]        fw,
  input  logic                    edge_seen,
  input  logic                    stale,
  output logic                    frame_pulse,
  output logic                    upd,
  output logic signed [ERR_W-1:0] err
);
  localparam logic signed [ERR_W-1:0] ERR_MIN = {1'b1, {(ERR_W-1){1'b0}}};
  localparam logic signed [ERR_W-1:0] ERR_MAX = {1'b0, {(ERR_W-1){1'b1}}};

  logic [ACC_W-1:0]        acc;
  logic [ACC_W:0]          acc_sum;
  logic signed [ERR_W-1:0] phase_now;
  logic signed [ERR_W-1:0] err_now;

  assign acc_sum   = {1'b0, acc} + {1'b0, fw};
  assign phase_now = $signed(acc[ACC_W-1 -: ERR_W]);
  assign err_now   = (phase_now == ERR_MIN) ? ERR_MAX : -phase_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc         <= '0;
      frame_pulse <= 1'b0;
    end else begin
      acc         <= acc_sum[ACC_W-1:0];
      frame_pulse <= acc_sum[ACC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd <= 1'b0;
      err <= '0;
    end else begin
      upd <= edge_seen & ~stale;
      if (edge_seen) err <= err_now;
    end
  end

  assert_frame_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> (acc < $past(fw)));
  assert_err_not_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> (err != ERR_MIN));
endmodule

// File: rtl/jtl_loop_filter.sv
module jtl_loop_filter #(
  parameter int FW_W = 32,
  parameter int ERR_W = 24,
  parameter int SH_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd,
  input  logic signed [ERR_W-1:0] err,
  input  logic [FW_W-1:0]         cfg_fw_init,
  input  logic [FW_W-1:0]         cfg_fw_min,
  input  logic [FW_W-1:0]         cfg_fw_max,
  input  logic [FW_W-1:0]         cfg_slew_step,
  input  logic [SH_W-1:0]         cfg_kp_shift,
  input  logic [SH_W-1:0]         cfg_ki_shift,
  output logic [FW_W-1:0]         fw,
  output logic                    fw_valid
);
  localparam int IW = FW_W + 2;

  logic signed [IW-1:0] integ;
  logic signed [IW-1:0] err_x, lo, hi;
  logic signed [IW-1:0] i_sum, i_sat, t_sum, t_sat;
  logic [FW_W-1:0]      tgt, diff, fw_next;

  assign err_x = {{(IW-ERR_W){err[ERR_W-1]}}, err};
  assign lo    = $signed({2'b00, cfg_fw_min});
  assign hi    = $signed({2'b00, cfg_fw_max});

  always_comb begin
    i_sum = integ + (err_x >>> cfg_ki_shift);
    if (i_sum < lo)      i_sat = lo;
    else if (i_sum > hi) i_sat = hi;
    else                 i_sat = i_sum;
    t_sum = i_sat + (err_x >>> cfg_kp_shift);
    if (t_sum < lo)      t_sat = lo;
    else if (t_sum > hi) t_sat = hi;
    else                 t_sat = t_sum;
    tgt = t_sat[FW_W-1:0];
    if (tgt >= fw) begin
      diff    = tgt - fw;
      fw_next = (diff > cfg_slew_step) ? fw + cfg_slew_step : tgt;
    end else begin
      diff    = fw - tgt;
      fw_next = (diff > cfg_slew_step) ? fw - cfg_slew_step : tgt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      integ    <= $signed({2'b00, cfg_fw_init});
      fw       <= cfg_fw_init;
      fw_valid <= 1'b0;
    end else begin
      fw_valid <= upd;
      if (upd) begin
        integ <= i_sat;
        fw    <= fw_next;
      end
    end
  end

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fw_valid |=> !fw_valid);
  assert_word_moves_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fw != $past(fw)) |-> fw_valid);
  assert_slew_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fw_valid |-> (((fw >= $past(fw)) ? (fw - $past(fw)) : ($past(fw) - fw)) <= cfg_slew_step));
  assert_integ_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fw_valid |-> ((integ >= lo) && (integ <= hi)));
endmodule

// File: rtl/jtl_lock_mon.sv
module jtl_lock_mon
  import jtl_pkg::*;
#(
  parameter int ERR_W      = 24,
  parameter int LOCK_CNT   = 16,
  parameter int UNLOCK_CNT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd,
  input  logic                    stale,
  input  logic signed [ERR_W-1:0] err,
  input  logic [ERR_W-2:0]        cfg_lock_thr,
  input  logic [ERR_W-2:0]        cfg_unlock_thr,
  output logic                    locked
);
  localparam int GW = $clog2(LOCK_CNT + 1);
  localparam int BW = $clog2(UNLOCK_CNT + 1);
  localparam logic [GW-1:0] GOOD_TOP = GW'(LOCK_CNT);
  localparam logic [BW-1:0] BAD_TOP  = BW'(UNLOCK_CNT);

  lock_state_e      state;
  logic [GW-1:0]    good_run, good_inc;
  logic [BW-1:0]    bad_run, bad_inc;
  logic [ERR_W-1:0] mag_full;
  logic [ERR_W-2:0] mag;
  logic             is_good, is_bad;

  assign mag_full = err[ERR_W-1] ? -err : err;
  assign mag      = mag_full[ERR_W-2:0];
  assign is_good  = mag < cfg_lock_thr;
  assign is_bad   = mag > cfg_unlock_thr;
  assign good_inc = (good_run == GOOD_TOP) ? GOOD_TOP : good_run + 1'b1;
  assign bad_inc  = bad_run + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= LK_SEARCH;
      good_run <= '0;
      bad_run  <= '0;
    end else if (stale) begin
      state    <= LK_SEARCH;
      good_run <= '0;
      bad_run  <= '0;
    end else if (upd) begin
      if (is_bad) begin
        good_run <= '0;
        if (bad_inc == BAD_TOP) begin
          state   <= LK_SEARCH;
          bad_run <= '0;
        end else begin
          bad_run <= bad_inc;
        end
      end else begin
        bad_run <= '0;
        if (is_good) begin
          good_run <= good_inc;
          if (good_inc == GOOD_TOP) state <= LK_HELD;
        end else begin
          good_run <= '0;
        end
      end
    end
  end

  assign locked = (state == LK_HELD);

  assert_stale_unlocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stale |=> !locked);
  assert_lock_needs_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(upd));
endmodule

// File: rtl/jitter_track_loop.sv
module jitter_track_loop #(
  parameter int FW_W        = 32,
  parameter int ERR_W       = 24,
  parameter int SH_W        = 5,
  parameter int TO_W        = 20,
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_CNT    = 16,
  parameter int UNLOCK_CNT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic [FW_W-1:0]   cfg_fw_init,
  input  logic [FW_W-1:0]   cfg_fw_min,
  input  logic [FW_W-1:0]   cfg_fw_max,
  input  logic [FW_W-1:0]   cfg_slew_step,
  input  logic [SH_W-1:0]   cfg_kp_shift,
  input  logic [SH_W-1:0]   cfg_ki_shift,
  input  logic [ERR_W-2:0]  cfg_lock_thr,
  input  logic [ERR_W-2:0]  cfg_unlock_thr,
  input  logic [TO_W-1:0]   cfg_timeout,
  output logic [FW_W-1:0]   fw_word,
  output logic              fw_valid,
  output logic              locked,
  output logic              frame_pulse
);
  logic                    edge_seen, stale, upd;
  logic signed [ERR_W-1:0] err;

  jtl_edge_sync #(.SYNC_STAGES(SYNC_STAGES), .TO_W(TO_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .cfg_timeout(cfg_timeout),
    .edge_seen(edge_seen), .stale(stale));

  jtl_phase_det #(.ACC_W(FW_W), .ERR_W(ERR_W)) u_pd (
    .clk(clk), .rst_n(rst_n), .fw(fw_word), .edge_seen(edge_seen), .stale(stale),
    .frame_pulse(frame_pulse), .upd(upd), .err(err));

  jtl_loop_filter #(.FW_W(FW_W), .ERR_W(ERR_W), .SH_W(SH_W)) u_lf (
    .clk(clk), .rst_n(rst_n), .upd(upd), .err(err),
    .cfg_fw_init(cfg_fw_init), .cfg_fw_min(cfg_fw_min), .cfg_fw_max(cfg_fw_max),
    .cfg_slew_step(cfg_slew_step), .cfg_kp_shift(cfg_kp_shift),
    .cfg_ki_shift(cfg_ki_shift), .fw(fw_word), .fw_valid(fw_valid));

  jtl_lock_mon #(.ERR_W(ERR_W), .LOCK_CNT(LOCK_CNT), .UNLOCK_CNT(UNLOCK_CNT)) u_lk (
    .clk(clk), .rst_n(rst_n), .upd(upd), .stale(stale), .err(err),
    .cfg_lock_thr(cfg_lock_thr), .cfg_unlock_thr(cfg_unlock_thr), .locked(locked));

  assert_no_strobe_when_stale_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stale && !edge_seen) |=> !upd);
endmodule

// File: tb/jitter_track_loop_tb.sv
module jitter_track_loop_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_in = 1'b0;
  logic [31:0] cfg_fw_init, cfg_fw_min, cfg_fw_max, cfg_slew_step;
  logic [4:0]  cfg_kp_shift, cfg_ki_shift;
  logic [22:0] cfg_lock_thr, cfg_unlock_thr;
  logic [19:0] cfg_timeout;
  logic [31:0] fw_word;
  logic        fw_valid, locked, frame_pulse;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int strobes = 0;
  bit started = 0;
  bit done = 0;
  longint prev_fw = 0;

  always #4 clk = ~clk;

  jitter_track_loop u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
    .cfg_fw_init(cfg_fw_init), .cfg_fw_min(cfg_fw_min), .cfg_fw_max(cfg_fw_max),
    .cfg_slew_step(cfg_slew_step), .cfg_kp_shift(cfg_kp_shift),
    .cfg_ki_shift(cfg_ki_shift), .cfg_lock_thr(cfg_lock_thr),
    .cfg_unlock_thr(cfg_unlock_thr), .cfg_timeout(cfg_timeout),
    .fw_word(fw_word), .fw_valid(fw_valid), .locked(locked), .frame_pulse(frame_pulse));

  // Behavioural reference model, advanced on every rising edge.
  bit     m_s1, m_s2, m_s3, m_upd, m_valid, m_fp, m_lock;
  longint m_acc, m_fw, m_integ, m_err, m_tcnt;
  int     m_good, m_bad;

  function automatic longint clampv(longint v, longint lo, longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  always @(posedge clk) begin
    longint ph, e, ni, tg, nfw, sum, mag;
    bit edge_now, stale_now;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_upd = 0; m_valid = 0; m_fp = 0; m_lock = 0;
      m_acc = 0; m_fw = cfg_fw_init; m_integ = cfg_fw_init; m_err = 0; m_tcnt = 0;
      m_good = 0; m_bad = 0;
    end else begin
      edge_now  = m_s2 && !m_s3;
      stale_now = (m_tcnt >= longint'(cfg_timeout));
      ph = (m_acc >> 8) & 64'hFFFFFF;
      if (ph >= 64'd8388608) ph = ph - 64'd16777216;
      e = (ph == -64'd8388608) ? 64'd8388607 : -ph;
      // lock monitor (R9 R10 R11)
      if (stale_now) begin
        m_lock = 0; m_good = 0; m_bad = 0;
      end else if (m_upd) begin
        mag = (m_err < 0) ? -m_err : m_err;
        if (mag > longint'(cfg_unlock_thr)) begin
          m_good = 0;
          if (m_bad + 1 == 4) begin m_lock = 0; m_bad = 0; end
          else m_bad = m_bad + 1;
        end else begin
          m_bad = 0;
          if (mag < longint'(cfg_lock_thr)) begin
            m_good = (m_good == 16) ? 16 : m_good + 1;
            if (m_good == 16) m_lock = 1;
          end else m_good = 0;
        end
      end
      // filter (R4 R5 R6 R7)
      nfw = m_fw;
      if (m_upd) begin
        ni = clampv(m_integ + (m_err >>> cfg_ki_shift), cfg_fw_min, cfg_fw_max);
        tg = clampv(ni + (m_err >>> cfg_kp_shift), cfg_fw_min, cfg_fw_max);
        if (tg >= m_fw) nfw = (tg - m_fw > longint'(cfg_slew_step)) ? m_fw + cfg_slew_step : tg;
        else            nfw = (m_fw - tg > longint'(cfg_slew_step)) ? m_fw - cfg_slew_step : tg;
        m_integ = ni;
      end
      m_valid = m_upd;
      // accumulator (R3 R8), uses the word before this edge
      sum = m_acc + m_fw;
      m_fp = (sum > 64'hFFFFFFFF);
      m_acc = sum & 64'hFFFFFFFF;
      m_fw = nfw;
      m_upd = edge_now && !stale_now;
      if (edge_now) m_err = e;
      if (edge_now) m_tcnt = 0;
      else if (m_tcnt != 64'hFFFFF) m_tcnt = m_tcnt + 1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ref_in;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    cycles++;
    if (started && !done) begin
      check(longint'(fw_word) == m_fw, "R3 R4 R5 fw_word", fw_word, m_fw);
      check(fw_valid == m_valid, "R2 R7 fw_valid", fw_valid, m_valid);
      check(locked == m_lock, "R9 R10 R11 locked", locked, m_lock);
      check(frame_pulse == m_fp, "R8 frame_pulse", frame_pulse, m_fp);
      if (fw_valid) begin
        longint d;
        d = (longint'(fw_word) >= prev_fw) ? longint'(fw_word) - prev_fw : prev_fw - longint'(fw_word);
        check(d <= longint'(cfg_slew_step), "R6 slew step", d, cfg_slew_step);
        strobes++;
      end
    end
    prev_fw = fw_word;
  end

  task automatic ref_period(input int per);
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      ref_in <= (i < per / 2);
    end
  endtask

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    longint held;
    cfg_fw_init   = 32'd42949673;
    cfg_fw_min    = 32'd35791394;
    cfg_fw_max    = 32'd53687091;
    cfg_slew_step = 32'd20000;
    cfg_kp_shift  = 5'd4;
    cfg_ki_shift  = 5'd8;
    cfg_lock_thr  = 23'h7FFFFF;
    cfg_unlock_thr = 23'h7FFFFF;
    cfg_timeout   = 20'd500;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(fw_word == cfg_fw_init, "R1 reset fw_word", fw_word, cfg_fw_init);
    check(!fw_valid && !locked && !frame_pulse, "R1 reset flags",
          {fw_valid, locked, frame_pulse}, 0);
    started = 1;
    @(negedge clk);
    rst_n <= 1'b1;
    // Steady reference, then R9 lock
    for (int k = 0; k < 30; k++) ref_period(100);
    check(locked == 1'b1, "R9 lock after good run", locked, 1);
    // Jittered reference
    for (int k = 0; k < 20; k++) ref_period((k % 2) ? 97 : 104);
    // R10: tighten thresholds so every nonzero error is bad
    cfg_lock_thr   = 23'd0;
    cfg_unlock_thr = 23'd0;
    for (int k = 0; k < 8; k++) ref_period((k % 2) ? 95 : 106);
    check(locked == 1'b0, "R10 unlock after bad run", locked, 0);
    cfg_lock_thr   = 23'h7FFFFF;
    cfg_unlock_thr = 23'h7FFFFF;
    for (int k = 0; k < 20; k++) ref_period(100);
    check(locked == 1'b1, "R9 relock", locked, 1);
    // Rate change glides under slew limit (R6)
    for (int k = 0; k < 40; k++) ref_period(90);
    // R4/R5 clamp: pull the ceiling just above the present word
    cfg_fw_max = fw_word + 32'd1000;
    for (int k = 0; k < 30; k++) ref_period(80);
    check(fw_word <= cfg_fw_max, "R4 R5 clamp at max", fw_word, cfg_fw_max);
    cfg_fw_max = 32'd53687091;
    for (int k = 0; k < 10; k++) ref_period(90);
    // R11: reference disappears
    repeat (20) @(negedge clk);
    held = fw_word;
    repeat (800) @(negedge clk);
    check(locked == 1'b0, "R11 stale drops lock", locked, 0);
    check(longint'(fw_word) == held, "R11 word held", fw_word, held);
    strobes = 0;
    ref_period(100);
    check(strobes == 0, "R11 first edge only re-arms", strobes, 0);
    strobes = 0;
    ref_period(100);
    check(strobes == 1, "R7 one strobe per edge", strobes, 1);
    for (int k = 0; k < 25; k++) ref_period(90);
    repeat (10) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule